// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Masked Output Writes and Gated Shared Interrupts

This block gives a processor bus sixteen general-purpose pins. Each pin has its own output enable and output level. Each pin's input level is sampled into a readable state register. The output latch is updated atomically: every write word carries a per-pin change mask in its upper half. Because of this, two agents can drive different pins without a read-modify-write race. The direction and interrupt enable registers are plain read/write words.

The low half of the pins each raise their own level interrupt line. The high half is combined into a single active-high request. Each high pin is first qualified by its own enable bit, then all are ORed together. One build option moves the enable bits of the high pins down to the low positions of the enable register. A second build option removes pins 1 to 5 from the dedicated lines and combines them into a second gated shared request in the same way.

A control word holds a clock enable and a soft reset. Writing 3 and then 1 brings the block up. Writing 2 parks it in reset with the clock stopped.

Top module: `gpx_ctrl`

## Requirements
- R1: The direction word at byte address 0x00 reads back what was written in bits 15:0. A 1 in bit i drives pad_oe[i] high.
- R2: A write to the output word at 0x08 uses bits 31:16 as a change mask and bits 15:0 as data. Pin i takes data bit i only where mask bit i is 1; all other pins keep their level. pad_out follows the latch.
- R3: A read of the output word returns the latch in bits 15:0 and zeros in bits 31:16.
- R4: While the clock enable is 1, the pin state word at 0x0C returns pad_in as sampled on the previous clock edge.
- R5: The interrupt enable word at 0x10 reads back the 16 bits written.
- R6: The control word at 0x14 has clock enable in bit 0 and soft reset in bit 1. It reads back in the same positions and is 0 after the bus reset.
- R7: While soft reset is 1, the direction, output and interrupt enable words read 0 and writes to them are ignored. Once soft reset is cleared, writes take effect again.
- R8: While the clock enable is 0, the pin state word keeps its last value and every interrupt output is low.
- R9: With default mapping, irq_grp_hi is the OR over pins 8 to 15 of (pin state AND enable bit of the same index).
- R10: irq_line[i] for pins 0 to 7 follows the sampled state of pin i when that pin is not in the low sharing group.
- R11: With PACK_HI=1, the enable bit for high pin 8+k is taken from bit k of the enable word.
- R12: With SHARE_LO=1, irq_line[5:1] are held low. irq_grp_lo is the OR over pins 1 to 5 of (pin state AND enable bit of the same index).
- R13: Writes to 0x0C and to unmapped addresses change no register. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, combinational from bus_addr |
| pad_in | input | 16 | Pin input levels |
| pad_out | output | 16 | Output latch |
| pad_oe | output | 16 | Per-pin output enable |
| irq_line | output | 8 | Dedicated interrupts for pins 0 to 7 |
| irq_grp_hi | output | 1 | Gated shared request of pins 8 to 15 |
| irq_grp_lo | output | 1 | Gated shared request of pins 1 to 5 (SHARE_LO only) |

## Verification
The masked write is swept with pseudo-random mask and data words against a running model of the latch. This includes all-zero and all-one masks. A design that ignores the mask, or inverts its sense, would corrupt untouched pins.

A second instance built with packed enables and low sharing receives the same stimulus. Its interrupt outputs are compared with an arithmetic model over many pin and enable patterns. A wrong enable index or a leaking dedicated line shows up directly on the interrupt outputs.

The bench also writes while soft reset is held, writes to the read-only and unmapped addresses, and changes the pins while the clock is gated off. An implementation that lets such writes through, or keeps sampling pins, would expose nonzero or updated words.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_OUT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STATE = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h14;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_OUT,
        SEL_STATE,
        SEL_IEN,
        SEL_CTRL,
        SEL_NONE
    } reg_sel_e;

    // bit 1 = soft reset, bit 0 = clock enable
    typedef struct packed {
        logic srst;
        logic clk_en;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_DIR:   return SEL_DIR;
            OFF_OUT:   return SEL_OUT;
            OFF_STATE: return SEL_STATE;
            OFF_IEN:   return SEL_IEN;
            OFF_CTRL:  return SEL_CTRL;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  ien_q,
    output logic [NPINS-1:0]  state_q,
    output ctrl_t             ctrl_q
);
    localparam int MASK_LSB = DATA_W / 2;
    localparam int PAD_W    = DATA_W - NPINS;

    reg_sel_e         sel;
    logic             wr_dir, wr_out, wr_ien, wr_ctrl;
    logic [NPINS-1:0] wr_mask, wr_data;

    assign sel     = decode_addr(addr);
    assign wr_dir  = wr && (sel == SEL_DIR);
    assign wr_out  = wr && (sel == SEL_OUT);
    assign wr_ien  = wr && (sel == SEL_IEN);
    assign wr_ctrl = wr && (sel == SEL_CTRL);
    assign wr_mask = wdata[MASK_LSB +: NPINS];
    assign wr_data = wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            out_q   <= '0;
            ien_q   <= '0;
            state_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.clk_en <= wdata[0];
                ctrl_q.srst   <= wdata[1];
            end
            if (ctrl_q.srst) begin
                dir_q <= '0;
                out_q <= '0;
                ien_q <= '0;
            end else begin
                if (wr_dir) dir_q <= wr_data;
                if (wr_out) out_q <= (out_q & ~wr_mask) | (wr_data & wr_mask);
                if (wr_ien) ien_q <= wr_data;
            end
            if (ctrl_q.clk_en) state_q <= pad_in;
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR:   rdata = {{PAD_W{1'b0}}, dir_q};
            SEL_OUT:   rdata = {{PAD_W{1'b0}}, out_q};
            SEL_STATE: rdata = {{PAD_W{1'b0}}, state_q};
            SEL_IEN:   rdata = {{PAD_W{1'b0}}, ien_q};
            SEL_CTRL:  rdata = {{(DATA_W-2){1'b0}}, ctrl_q};
            default:   rdata = '0;
        endcase
    end

    // R7: soft reset clears the writable words on the next edge
    assert_srst_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.srst |=> (dir_q == '0 && out_q == '0 && ien_q == '0));

    // R2: pins outside the mask keep their level
    assert_mask_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_out && !ctrl_q.srst) |=> (((out_q ^ $past(out_q)) & ~$past(wr_mask)) == '0));

    // R2: without an output write or soft reset the latch holds
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_out && !ctrl_q.srst) |=> $stable(out_q));

    // R8: sampling stops while the clock enable is low
    assert_state_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.clk_en |=> $stable(state_q));

    // R6: control word takes the written bits
    assert_ctrl_load_R6: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q == $past(wdata[1:0])));
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
    parameter int NPINS      = 16,
    parameter int SHARE_BASE = 8,
    parameter bit PACK_HI    = 1'b0,
    parameter bit SHARE_LO   = 1'b0,
    parameter int LO_FIRST   = 1,
    parameter int LO_LAST    = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clk_en,
    input  logic [NPINS-1:0]      state_q,
    input  logic [NPINS-1:0]      ien_q,
    output logic [SHARE_BASE-1:0] irq_line,
    output logic                  irq_grp_hi,
    output logic                  irq_grp_lo
);
    localparam int NHI = NPINS - SHARE_BASE;

    logic [NHI-1:0]        hi_gate;
    logic [SHARE_BASE-1:0] lo_gate;
    logic [SHARE_BASE-1:0] ded;
    logic                  unused_ien_parity;

    assign unused_ien_parity = ^ien_q;

    for (genvar k = 0; k < NHI; k++) begin : g_hi
        if (PACK_HI) begin : g_packed
            assign hi_gate[k] = state_q[SHARE_BASE+k] & ien_q[k];
        end else begin : g_direct
            assign hi_gate[k] = state_q[SHARE_BASE+k] & ien_q[SHARE_BASE+k];
        end
    end

    for (genvar j = 0; j < SHARE_BASE; j++) begin : g_lo
        if (SHARE_LO && j >= LO_FIRST && j <= LO_LAST) begin : g_shared
            assign ded[j]     = 1'b0;
            assign lo_gate[j] = state_q[j] & ien_q[j];
        end else begin : g_own
            assign ded[j]     = state_q[j];
            assign lo_gate[j] = 1'b0;
        end
    end

    assign irq_line   = clk_en ? ded : '0;
    assign irq_grp_hi = clk_en & (|hi_gate);
    assign irq_grp_lo = clk_en & (|lo_gate);

    // R8: clock gate silences every request
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> (irq_line == '0 && !irq_grp_hi && !irq_grp_lo));

    // R9: a shared request needs some high pin that is set
    assert_grp_needs_pin_R9: assert property (@(posedge clk) disable iff (rst)
        irq_grp_hi |-> (state_q[NPINS-1:SHARE_BASE] != '0));

    // R10: a dedicated line only rises for a set pin
    assert_line_needs_pin_R10: assert property (@(posedge clk) disable iff (rst)
        ((irq_line & ~state_q[SHARE_BASE-1:0]) == '0));
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
    import gpx_pkg::*;
#(
    parameter int NPINS      = 16,
    parameter int DATA_W     = 32,
    parameter int SHARE_BASE = 8,
    parameter bit PACK_HI    = 1'b0,
    parameter bit SHARE_LO   = 1'b0,
    parameter int LO_FIRST   = 1,
    parameter int LO_LAST    = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    output logic [SHARE_BASE-1:0] irq_line,
    output logic                  irq_grp_hi,
    output logic                  irq_grp_lo
);
    logic [NPINS-1:0] dir_q, out_q, ien_q, state_q;
    ctrl_t            ctrl_q;

    gpx_regs #(
        .NPINS  (NPINS),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .pad_in  (pad_in),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ien_q   (ien_q),
        .state_q (state_q),
        .ctrl_q  (ctrl_q)
    );

    gpx_irq #(
        .NPINS      (NPINS),
        .SHARE_BASE (SHARE_BASE),
        .PACK_HI    (PACK_HI),
        .SHARE_LO   (SHARE_LO),
        .LO_FIRST   (LO_FIRST),
        .LO_LAST    (LO_LAST)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (ctrl_q.clk_en),
        .state_q    (state_q),
        .ien_q      (ien_q),
        .irq_line   (irq_line),
        .irq_grp_hi (irq_grp_hi),
        .irq_grp_lo (irq_grp_lo)
    );

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    // R3: output word never shows anything in its mask half
    assert_out_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_OUT) |-> (bus_rdata[DATA_W-1:DATA_W/2] == '0));
endmodule

// File: tb/gpx_ctrl_tb.sv
module gpx_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [15:0] pad_in = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [15:0] pout_a, poe_a, pout_b, poe_b;
    logic [7:0]  line_a, line_b;
    logic        hi_a, lo_a, hi_b, lo_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpx_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pad_in(pad_in),
        .pad_out(pout_a), .pad_oe(poe_a), .irq_line(line_a),
        .irq_grp_hi(hi_a), .irq_grp_lo(lo_a)
    );

    gpx_ctrl #(.PACK_HI(1'b1), .SHARE_LO(1'b1)) u_dut_alt (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pad_in(pad_in),
        .pad_out(pout_b), .pad_oe(poe_b), .irq_line(line_b),
        .irq_grp_hi(hi_b), .irq_grp_lo(lo_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = rdata_a;
    endtask

    task automatic set_pads(input logic [15:0] p);
        @(negedge clk);
        pad_in = p;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, seed;
        logic [15:0] exp_out, m, d, ien, pads, held;
        logic [7:0]  ienb;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(8'h00, r); chk("R1", "dir after reset", r, 32'h0);
        rd(8'h08, r); chk("R2", "out after reset", r, 32'h0);
        rd(8'h10, r); chk("R5", "ien after reset", r, 32'h0);
        rd(8'h14, r); chk("R6", "ctrl after reset", r, 32'h0);
        chk("R1", "pad_oe after reset", {16'h0, poe_a}, 32'h0);
        chk("R8", "irqs with clock off", {22'h0, line_a, hi_a, lo_a}, 32'h0);

        // bring-up sequence
        wr(8'h14, 32'h3);
        rd(8'h14, r); chk("R6", "ctrl reset+clock", r, 32'h3);
        wr(8'h14, 32'h1);
        rd(8'h14, r); chk("R6", "ctrl clock only", r, 32'h1);

        // R1 direction sweep
        for (int k = 0; k < 16; k++) begin
            d = 16'hA5C3 ^ (16'h1 << k);
            wr(8'h00, {16'hFFFF, d});
            rd(8'h00, r); chk("R1", "dir readback", r, {16'h0, d});
            chk("R1", "pad_oe", {16'h0, poe_a}, {16'h0, d});
        end

        // R2/R3 masked output writes
        exp_out = 16'h0;
        seed = 32'h1234_5678;
        for (int k = 0; k < 48; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            m = seed[31:16];
            d = seed[15:0];
            if (k == 0) m = 16'hFFFF;
            if (k == 1) m = 16'h0000;
            wr(8'h08, {m, d});
            exp_out = (exp_out & ~m) | (d & m);
            rd(8'h08, r);
            chk("R2", "masked out latch", {16'h0, r[15:0]}, {16'h0, exp_out});
            chk("R3", "out upper half", {16'h0, r[31:16]}, 32'h0);
            chk("R2", "pad_out", {16'h0, pout_a}, {16'h0, exp_out});
        end

        // R4 pin state sampling
        for (int k = 0; k < 16; k++) begin
            pads = 16'h8001 ^ (16'h3 << k);
            set_pads(pads);
            rd(8'h0C, r); chk("R4", "pin state", r, {16'h0, pads});
        end

        // R5 enable readback
        wr(8'h10, 32'hDEAD_5AF0);
        rd(8'h10, r); chk("R5", "ien readback", r, 32'h0000_5AF0);

        // R9-R12 interrupt combining on both builds
        seed = 32'hCAFE_0001;
        for (int k = 0; k < 64; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            ien  = seed[31:16];
            pads = seed[15:0];
            if (k[0]) ien = ien & 16'h0F0F;
            wr(8'h10, {16'h0, ien});
            set_pads(pads);
            chk("R10", "dedicated lines", {24'h0, line_a}, {24'h0, pads[7:0]});
            chk("R9", "shared high", {31'h0, hi_a}, {31'h0, |(pads[15:8] & ien[15:8])});
            chk("R9", "no low group by default", {31'h0, lo_a}, 32'h0);
            ienb = ien[7:0];
            chk("R11", "packed shared high", {31'h0, hi_b}, {31'h0, |(pads[15:8] & ienb)});
            chk("R12", "dedicated lines with low sharing", {24'h0, line_b},
                {24'h0, pads[7:0] & 8'hC1});
            chk("R12", "shared low", {31'h0, lo_b}, {31'h0, |(pads[5:1] & ien[5:1])});
        end

        // R13 read-only and unmapped addresses
        wr(8'h00, 32'h0000_1357);
        wr(8'h08, 32'hFFFF_2468);
        wr(8'h10, 32'h0000_0F0F);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h00, r); chk("R13", "dir after stray writes", r, 32'h0000_1357);
        rd(8'h08, r); chk("R13", "out after stray writes", r, 32'h0000_2468);
        rd(8'h10, r); chk("R13", "ien after stray writes", r, 32'h0000_0F0F);
        rd(8'h14, r); chk("R13", "ctrl after stray writes", r, 32'h1);
        rd(8'h04, r); chk("R13", "unmapped read 0x04", r, 32'h0);
        rd(8'h1C, r); chk("R13", "unmapped read 0x1C", r, 32'h0);

        // R8 clock gate
        wr(8'h10, 32'h0000_FFFF);
        held = 16'hFF81;
        set_pads(held);
        chk("R8", "grp high before gate", {31'h0, hi_a}, 32'h1);
        wr(8'h14, 32'h0);
        set_pads(16'h007E);
        rd(8'h0C, r); chk("R8", "state held", r, {16'h0, held});
        chk("R8", "irqs low while gated", {22'h0, line_a, hi_a, lo_a}, 32'h0);
        chk("R8", "alt irqs low while gated", {22'h0, line_b, hi_b, lo_b}, 32'h0);
        wr(8'h14, 32'h1);
        rd(8'h0C, r); chk("R8", "state resumes", r, 32'h0000_007E);

        // R7 soft reset
        wr(8'h14, 32'h3);
        rd(8'h00, r); chk("R7", "dir in soft reset", r, 32'h0);
        rd(8'h08, r); chk("R7", "out in soft reset", r, 32'h0);
        rd(8'h10, r); chk("R7", "ien in soft reset", r, 32'h0);
        chk("R7", "pad_oe in soft reset", {16'h0, poe_a}, 32'h0);
        wr(8'h00, 32'h0000_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0000_FFFF);
        rd(8'h00, r); chk("R7", "dir write ignored", r, 32'h0);
        rd(8'h08, r); chk("R7", "out write ignored", r, 32'h0);
        rd(8'h10, r); chk("R7", "ien write ignored", r, 32'h0);
        wr(8'h14, 32'h1);
        wr(8'h00, 32'h0000_00F0);
        rd(8'h00, r); chk("R7", "dir write after release", r, 32'h0000_00F0);
        wr(8'h14, 32'h2);
        rd(8'h14, r); chk("R6", "parked reset, clock off", r, 32'h2);
        rd(8'h00, r); chk("R7", "dir cleared when parked", r, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule